// File: doc/BRIEF.md
# Input Edge Counter and Timestamp Capture

This block watches one already-synchronized input pin and reacts to the edges chosen by a two-bit select (rising, falling, both or none). It has two modes. In count mode it tallies the accepted edges and raises a one-cycle completion pulse once the tally reaches the span set by the difference between a load value and a match value. It then restarts from zero (periodic) or freezes until it is re-armed (one-shot). In time mode it latches the value of a free-running counter into a capture register on every accepted edge, which timestamps the edge.

The count is 24 bits wide: a 16-bit counter and an 8-bit extension above it. The readable capture word is 32 bits. Bits 23:0 carry the tally or the timestamp, and bits 31:24 are always zero. A separate output always shows the live free-running count, whatever the capture register holds. Dropping the enable freezes the free-running count, makes the unit ignore edges, and re-arms the edge tally.

Top module: `edge_capture_unit`

## Requirements
- R1: After reset, cap_word, live_count, cap_evt and count_done are all zero.
- R2: While enable is 1, live_count rises by exactly one per clock. While enable is 0, it keeps its value.
- R3: edge_sel 2'b01 accepts only rising edges (pin 0 then 1 on consecutive samples), 2'b10 accepts only falling edges (1 then 0), 2'b11 accepts both, and 2'b00 accepts none. At most one edge is accepted per clock.
- R4: In count mode (time_mode = 0), cap_word[23:0] shows the number of edges accepted since the last re-arm or reload. Both this value and a one-cycle cap_evt pulse take effect in the clock after the edge is detected.
- R5: The accepted edge that brings the tally to load_val − match_val also pulses count_done, in the same cycle as its cap_evt. With periodic = 1, cap_word[23:0] reads 0 in that cycle.
- R6: With periodic = 0, the tally holds at load_val − match_val after count_done. Further edges give no cap_evt and no count_done until enable is taken low, which clears the tally to 0.
- R7: In count mode with load_val ≤ match_val, no edge is counted: cap_word stays unchanged and neither cap_evt nor count_done pulses.
- R8: In time mode (time_mode = 1), each accepted edge loads cap_word[23:0] with the live_count value present in the cycle the edge was detected, and pulses cap_evt one clock later. count_done stays 0.
- R9: cap_word[31:24] always reads zero.
- R10: While enable is 0, edges are ignored: cap_evt stays 0 and the captured value does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| enable | input | 1 | Runs the free-running count and edge acceptance; low re-arms the tally |
| pin | input | 1 | Synchronized capture input |
| edge_sel | input | 2 | Edge choice: bit 0 rising, bit 1 falling |
| time_mode | input | 1 | 0 = edge count, 1 = edge timestamp |
| periodic | input | 1 | Count mode: 1 = reload after completion, 0 = one-shot |
| load_val | input | 24 | Interval load value |
| match_val | input | 24 | Match value; the edge span is load_val − match_val |
| cap_word | output | 32 | Tally or timestamp in bits 23:0, zero above |
| live_count | output | 24 | Free-running count |
| cap_evt | output | 1 | One-cycle pulse per accepted edge |
| count_done | output | 1 | One-cycle pulse when the edge span is reached |

## Verification
The edge that completes the span updates the tally, pulses cap_evt and pulses count_done, all in the same cycle. In periodic mode that same update also returns the tally to zero. The bench toggles the pin on every clock so that the completing edge follows directly on the one before it. It predicts each completing edge as a single expected item with the done flag and a tally of zero, or of the span in one-shot mode. The monitor then checks that cap_evt and count_done come out together with that value, and never count_done alone.

// File: rtl/edge_capture_unit.sv
module edge_capture_unit #(
  parameter int CNT_W  = 16,
  parameter int EXT_W  = 8,
  parameter int WORD_W = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   enable,
  input  logic                   pin,
  input  logic [1:0]             edge_sel,
  input  logic                   time_mode,
  input  logic                   periodic,
  input  logic [CNT_W+EXT_W-1:0] load_val,
  input  logic [CNT_W+EXT_W-1:0] match_val,
  output logic [WORD_W-1:0]      cap_word,
  output logic [CNT_W+EXT_W-1:0] live_count,
  output logic                   cap_evt,
  output logic                   count_done
);
  localparam int W   = CNT_W + EXT_W;
  localparam int PAD = WORD_W - W;
  localparam logic [W-1:0] ONE = W'(1);

  logic         prev, halted;
  logic [W-1:0] live, seen, stamp;

  wire rise    = pin & ~prev;
  wire fall    = ~pin & prev;
  wire hit     = enable & ((rise & edge_sel[0]) | (fall & edge_sel[1]));
  wire [W-1:0] span = load_val - match_val;
  wire cfg_ok  = load_val > match_val;
  wire take    = hit & ~time_mode & cfg_ok & ~halted;
  wire last    = take & ((seen + ONE) == span);
  wire grab    = hit & time_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev       <= 1'b0;
      live       <= '0;
      seen       <= '0;
      stamp      <= '0;
      halted     <= 1'b0;
      cap_evt    <= 1'b0;
      count_done <= 1'b0;
    end else begin
      prev       <= pin;
      cap_evt    <= take | grab;
      count_done <= last;
      if (enable) live <= live + ONE;
      if (grab) stamp <= live;
      if (!enable) begin
        seen   <= '0;
        halted <= 1'b0;
      end else if (last) begin
        seen   <= periodic ? '0 : span;
        halted <= ~periodic;
      end else if (take) begin
        seen   <= seen + ONE;
      end
    end
  end

  assign live_count = live;
  assign cap_word   = {{PAD{1'b0}}, (time_mode ? stamp : seen)};

  AST_DONE_WITH_EVT: assert property (@(posedge clk) disable iff (!rst_n)
    count_done |-> cap_evt); // R5

  AST_LIVE_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(enable)) |-> live == $past(live) + ONE); // R2

  AST_LIVE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(enable)) |-> $stable(live)); // R2

  AST_NO_EVT_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(enable)) |-> !cap_evt); // R10

  AST_TIME_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && $past(time_mode)) |-> !count_done); // R8

  AST_BAD_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(time_mode) && ($past(load_val) <= $past(match_val))) |-> !cap_evt); // R7

  AST_STAMP: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && cap_evt && $past(time_mode)) |-> stamp == $past(live)); // R8
endmodule

// File: tb/sim_edge_capture_unit.sv
`timescale 1ns/1ps
module sim_edge_capture_unit;
  logic        clk = 0, rst_n = 0, enable = 0, pin = 0;
  logic [1:0]  edge_sel = 2'b01;
  logic        time_mode = 0, periodic = 1;
  logic [23:0] load_val = 24'd5, match_val = 24'd2;
  logic [31:0] cap_word;
  logic [23:0] live_count;
  logic        cap_evt, count_done;

  edge_capture_unit u0 (.*);

  always #10 clk = ~clk;

  typedef struct { logic [23:0] val; logic done; string req; } item_t;
  item_t q[$];
  int checks = 0, errors = 0;
  logic [23:0] m_seen = 0;
  logic        m_halt = 0;
  bit          finished = 0;

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // monitor
  always @(negedge clk) if (rst_n && !finished) begin
    if (cap_evt || count_done) begin
      if (q.size() == 0) begin
        chk("R10/R6/R7 unexpected event", {30'd0, cap_evt, count_done}, 32'd0);
      end else begin
        item_t it;
        it = q.pop_front();
        chk({it.req, " cap_evt"}, {31'd0, cap_evt}, 32'd1);
        chk({it.req, " value"}, cap_word, {8'd0, it.val});
        chk({it.req, " done"}, {31'd0, count_done}, {31'd0, it.done});
      end
    end
  end

  // driver: flips pin at a negedge and predicts the result
  task automatic toggle(string req);
    logic np, hit;
    logic [23:0] ts, span;
    item_t it;
    @(negedge clk);
    ts = live_count;
    np = ~pin;
    hit = enable && ((np && !pin && edge_sel[0]) || (!np && pin && edge_sel[1]));
    pin = np;
    span = load_val - match_val;
    if (!enable) begin m_seen = 0; m_halt = 0; end
    if (hit) begin
      it.req = req;
      if (time_mode) begin
        it.val = ts; it.done = 0; q.push_back(it);
      end else if (load_val > match_val && !m_halt) begin
        if (m_seen + 1 == span) begin
          it.done = 1;
          if (periodic) m_seen = 0; else begin m_seen = span; m_halt = 1; end
        end else begin
          it.done = 0; m_seen = m_seen + 1;
        end
        it.val = m_seen; q.push_back(it);
      end
    end
  endtask

  task automatic rearm();
    @(negedge clk); enable = 0;
    @(negedge clk); enable = 1;
    m_seen = 0; m_halt = 0;
  endtask

  task automatic drain();
    repeat (3) @(negedge clk);
    chk("queue drained", q.size(), 0);
  endtask

  initial begin
    logic [23:0] l0;
    logic [31:0] held;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    chk("R1 cap_word", cap_word, 0);
    chk("R1 live_count", {8'd0, live_count}, 0);
    chk("R1 pulses", {30'd0, cap_evt, count_done}, 0);
    // R2 running
    enable = 1;
    l0 = live_count;
    repeat (10) @(negedge clk);
    chk("R2 live increments", {8'd0, live_count}, {8'd0, l0 + 24'd10});
    // R3/R4/R5 rising, periodic, span 3: back-to-back toggles
    for (int i = 0; i < 12; i++) toggle("R4/R5 periodic rising");
    drain();
    // R3 falling only
    rearm(); edge_sel = 2'b10;
    for (int i = 0; i < 6; i++) toggle("R3 falling");
    drain();
    // R3 both edges
    rearm(); edge_sel = 2'b11;
    for (int i = 0; i < 7; i++) toggle("R3 both");
    drain();
    // R3 none
    rearm(); edge_sel = 2'b00;
    held = cap_word;
    for (int i = 0; i < 4; i++) toggle("R3 none");
    drain();
    chk("R3 none leaves tally", cap_word, held);
    // R6 one-shot, span 4
    rearm(); edge_sel = 2'b01; periodic = 0; load_val = 24'd10; match_val = 24'd6;
    for (int i = 0; i < 14; i++) toggle("R6 one-shot");
    drain();
    chk("R6 tally held at span", cap_word, 32'd4);
    rearm();
    @(negedge clk);
    chk("R6 re-arm clears tally", cap_word, 0);
    for (int i = 0; i < 4; i++) toggle("R6 after re-arm");
    drain();
    // R7 bad configurations
    periodic = 1; load_val = 24'd2; match_val = 24'd2; rearm();
    for (int i = 0; i < 6; i++) toggle("R7 equal");
    drain();
    chk("R7 equal no count", cap_word, 0);
    load_val = 24'd1; match_val = 24'd4;
    for (int i = 0; i < 6; i++) toggle("R7 below");
    drain();
    chk("R7 below no count", cap_word, 0);
    // R8/R9 time mode
    time_mode = 1; edge_sel = 2'b11; rearm();
    for (int i = 0; i < 5; i++) begin
      toggle("R8 timestamp");
      repeat (i) @(negedge clk);
    end
    drain();
    chk("R9 top byte zero", {24'd0, cap_word[31:24]}, 0);
    // R10 disabled
    @(negedge clk); enable = 0;
    held = cap_word;
    l0 = live_count;
    for (int i = 0; i < 6; i++) toggle("R10 disabled");
    drain();
    chk("R10 capture unchanged", cap_word, held);
    chk("R2 live holds when disabled", {8'd0, live_count}, {8'd0, l0});
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(20 * 200000);
    if (!finished) begin
      finished = 1;
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule